// File: doc/BRIEF.md
# Processor Bus-Speed Selector with Return Hold-Off

This block sits on a processor accelerator card and decides whether the processor is clocked from the fast local source or from the slower mainboard source. Work that stays in local memory runs at the fast rate. Any access that targets the mainboard must run at the slow rate. The two rates in the intended system are 50 MHz and 16 MHz. The block drives a rate-select signal and a pair of gate enables. The enables hand over from one clock to the other with a dead gap between them, so the clock that results never carries a runt pulse.

Switching into the slow rate costs a lot of time. On a 16-bit mainboard bus a 32-bit read is split into two word accesses that follow each other closely, and going back to fast between the two halves would pay the switch cost twice. For this reason, once a mainboard access has been acknowledged, the block keeps the slow rate until a set number of slow-clock ticks have passed with no new mainboard request. That count is measured by a chain of flip-flops that fills one stage per tick and is emptied whenever a new unacknowledged mainboard request shows up. The rate select may only move while the address strobe is negated, so a bus cycle that has already started never sees the rate change under it.

The whole block runs on one reference clock. `slow_tick` is a one-cycle pulse marking each slow-clock period. Clock generation and bus protocol decoding happen outside the block.

Top module: `bus_speed_switch`

## Requirements
- R1: While reset is active, and after it is released, the outputs read use_slow=0, en_fast=1, en_slow=0 until the first mainboard request.
- R2: In the fast state, a rising edge that samples board_sel=1 and as_n=1 sets use_slow=1 and clears en_fast at that edge. Both enables stay 0 for exactly GAP_CYCLES cycles, and then en_slow becomes 1.
- R3: use_slow does not change at any clock edge where as_n is sampled low (0 = strobe asserted).
- R4: en_fast and en_slow are never 1 at the same time.
- R5: The hold-off count is reset on any edge that samples board_sel=1 with ack_n=1 (ack_n is active low). The return to fast starts only at an edge in the slow state that samples as_n=1 and board_sel=0, and only after HOLD_TICKS slow_tick pulses have been counted since the last such reset.
- R6: A mainboard request that arrives before the hold-off has expired keeps the block in the slow state. Two closely spaced word accesses produce one switch to slow and one switch back.
- R7: Returning to fast, use_slow=0 and en_slow=0 at the starting edge. Both enables stay 0 for exactly GAP_CYCLES cycles, and then en_fast becomes 1.
- R8: Mainboard accesses separated by an idle period longer than the hold-off produce two separate switches to slow.
- R9: The hold-off advances only on cycles where slow_tick=1. With no ticks, the block stays in the slow state indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| board_sel | input | 1 | Address decode: the current or next access targets the mainboard |
| as_n | input | 1 | Address strobe, active low |
| ack_n | input | 1 | Access acknowledge, active low |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| use_slow | output | 1 | Rate select: 1 = slow mainboard clock, 0 = fast local clock |
| en_fast | output | 1 | Gate enable for the fast clock |
| en_slow | output | 1 | Gate enable for the slow clock |

## Verification
A wrong hold-off state shows at the ports one edge after the slow state is left. use_slow falls too early, which breaks the single-switch behaviour for paired word accesses, or it never falls while ticks are present. A wrong handover state shows either as both enables high or as a dead gap of the wrong length; this appears within GAP_CYCLES+1 cycles of the select change. The bench runs a cycle-level model built from the requirements alongside the design and compares all three outputs on every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [1:0] {
    SP_FAST    = 2'd0,
    SP_TO_SLOW = 2'd1,
    SP_SLOW    = 2'd2,
    SP_TO_FAST = 2'd3
  } spd_state_e;
endpackage

// File: rtl/bss_holdoff_chain.sv
// Delay line of flip-flops that measures the return hold-off in slow ticks.
module bss_holdoff_chain #(
  parameter int HOLD_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic done
);
  logic [HOLD_TICKS-1:0] stage_q;

  for (genvar i = 0; i < HOLD_TICKS; i++) begin : g_stage
    logic stage_d;
    logic feed;
    if (i == 0) begin : g_head
      assign feed = 1'b1;
    end else begin : g_body
      assign feed = stage_q[i-1];
    end

    always_comb begin
      stage_d = stage_q[i];
      if (clear) begin
        stage_d = 1'b0;
      end else if (tick) begin
        stage_d = feed;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[i] <= 1'b0;
      end else begin
        stage_q[i] <= stage_d;
      end
    end
  end

  assign done = stage_q[HOLD_TICKS-1];

  // R9: a full chain stays full (or empties) only through tick/clear; without tick it cannot newly fill
  a_r9_fill_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tick));
endmodule

// File: rtl/bss_speed_fsm.sv
// Handover sequencer: disables the running clock, waits a dead gap, enables the other one.
module bss_speed_fsm
  import bss_pkg::*;
#(
  parameter int GAP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_slow,
  input  logic req_fast,
  output logic use_slow,
  output logic en_fast,
  output logic en_slow
);
  localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

  spd_state_e       state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_end;
  logic             sel_d;

  assign gap_end = (gap_q == GAP_LAST);

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    unique case (state_q)
      SP_FAST: begin
        if (req_slow) begin
          state_d = SP_TO_SLOW;
          gap_d   = '0;
        end
      end
      SP_TO_SLOW: begin
        if (gap_end) state_d = SP_SLOW;
        else         gap_d   = gap_q + 1'b1;
      end
      SP_SLOW: begin
        if (req_fast) begin
          state_d = SP_TO_FAST;
          gap_d   = '0;
        end
      end
      SP_TO_FAST: begin
        if (gap_end) state_d = SP_FAST;
        else         gap_d   = gap_q + 1'b1;
      end
      default: state_d = SP_FAST;
    endcase
    sel_d = (state_d == SP_TO_SLOW) || (state_d == SP_SLOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SP_FAST;
      gap_q    <= '0;
      use_slow <= 1'b0;
    end else begin
      state_q  <= state_d;
      gap_q    <= gap_d;
      use_slow <= sel_d;
    end
  end

  assign en_fast = (state_q == SP_FAST);
  assign en_slow = (state_q == SP_SLOW);

  a_r4_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_fast && en_slow));
  a_r2_slow_gap_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_slow) |-> !$past(en_fast));
  a_r7_fast_gap_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_fast) |-> !$past(en_slow));
endmodule

// File: rtl/bus_speed_switch.sv
module bus_speed_switch #(
  parameter int HOLD_TICKS = 2,
  parameter int GAP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic board_sel,
  input  logic as_n,
  input  logic ack_n,
  input  logic slow_tick,
  output logic use_slow,
  output logic en_fast,
  output logic en_slow
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       hold_clear;
  logic       hold_done;
  logic       req_slow;
  logic       req_fast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // an unacknowledged mainboard request restarts the hold-off
  assign hold_clear = board_sel && ack_n;
  // rate changes are only requested between bus cycles
  assign req_slow   = as_n && board_sel;
  assign req_fast   = as_n && !board_sel && hold_done;

  bss_holdoff_chain #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (hold_clear),
    .tick  (slow_tick),
    .done  (hold_done)
  );

  bss_speed_fsm #(.GAP_CYCLES(GAP_CYCLES)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_slow (req_slow),
    .req_fast (req_fast),
    .use_slow (use_slow),
    .en_fast  (en_fast),
    .en_slow  (en_slow)
  );

  a_r3_select_frozen_in_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !as_n |=> $stable(use_slow));
  a_r5_fast_after_holdoff: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(use_slow) |-> $past(hold_done && !board_sel));
  a_r2_slow_needs_decode: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(use_slow) |-> $past(board_sel && as_n));
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_sync_n |-> (en_fast && !en_slow && !use_slow));
endmodule

// File: tb/bus_speed_switch_test.sv
`timescale 1ns/1ps
module bus_speed_switch_test;
  localparam int HOLD = 2;
  localparam int GAP  = 2;

  logic clk = 1'b0;
  logic rst_n, board_sel, as_n, ack_n, slow_tick;
  logic use_slow, en_fast, en_slow;
  int   nchk = 0, nerr = 0;
  int   tick_mode = 0;   // 0 none, 1 every third cycle, 2 random
  int   tcnt = 0;
  bit   model_on = 1'b0;
  int   m_state = 0, m_gap = 0, m_cnt = 0;
  int   rises = 0, falls = 0;
  logic prev_use = 1'b0;

  always #2.5 clk = ~clk;

  bus_speed_switch #(.HOLD_TICKS(HOLD), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .board_sel(board_sel), .as_n(as_n), .ack_n(ack_n),
    .slow_tick(slow_tick), .use_slow(use_slow), .en_fast(en_fast), .en_slow(en_slow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tcnt <= (tcnt == 2) ? 0 : tcnt + 1;
    case (tick_mode)
      1:       slow_tick <= (tcnt == 2);
      2:       slow_tick <= ($urandom % 3 == 0);
      default: slow_tick <= 1'b0;
    endcase
  end

  // reference model derived from the requirements
  always @(posedge clk) begin
    if (!model_on) begin
      m_state <= 0; m_gap <= 0; m_cnt <= 0;
    end else begin
      if (board_sel && ack_n) m_cnt <= 0;
      else if (slow_tick && m_cnt < HOLD) m_cnt <= m_cnt + 1;
      case (m_state)
        0: if (board_sel && as_n) begin m_state <= 1; m_gap <= 0; end
        1: if (m_gap == GAP - 1) m_state <= 2; else m_gap <= m_gap + 1;
        2: if (as_n && !board_sel && m_cnt >= HOLD) begin m_state <= 3; m_gap <= 0; end
        default: if (m_gap == GAP - 1) m_state <= 0; else m_gap <= m_gap + 1;
      endcase
    end
  end

  always @(posedge clk) begin
    #1;
    if (use_slow && !prev_use) rises++;
    if (!use_slow && prev_use) falls++;
    prev_use = use_slow;
    if (model_on) begin
      check(use_slow == (m_state == 1 || m_state == 2), "R2/R5/R7", "use_slow vs model",
            use_slow, (m_state == 1 || m_state == 2));
      check(en_fast == (m_state == 0), "R2/R7", "en_fast vs model", en_fast, m_state == 0);
      check(en_slow == (m_state == 2), "R2/R7", "en_slow vs model", en_slow, m_state == 2);
      check(!(en_fast && en_slow), "R4", "both enables", 1, 0);
    end
  end

  task automatic board_access();
    @(negedge clk); board_sel = 1'b1; as_n = 1'b1; ack_n = 1'b1;
    for (int k = 0; k < 40 && !en_slow; k++) @(negedge clk);
    as_n = 1'b0;
    repeat (2) @(negedge clk);
    ack_n = 1'b0;
    @(negedge clk);
    as_n = 1'b1; ack_n = 1'b1; board_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int r0, f0, gapcnt;
    void'($urandom(32'd4242));
    rst_n = 1'b0; board_sel = 1'b0; as_n = 1'b1; ack_n = 1'b1;
    repeat (3) @(negedge clk);
    check(use_slow == 0 && en_fast == 1 && en_slow == 0, "R1", "outputs in reset",
          {use_slow, en_fast, en_slow}, 3'b010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(use_slow == 0 && en_fast == 1 && en_slow == 0, "R1", "outputs after reset",
          {use_slow, en_fast, en_slow}, 3'b010);
    model_on = 1'b1;

    // R3: decode with strobe asserted must not switch
    board_sel = 1'b1; as_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(use_slow == 0, "R3", "select moved during strobe", use_slow, 0);
    end
    as_n = 1'b1;
    @(negedge clk);
    check(use_slow == 1 && en_fast == 0, "R2", "select at request edge",
          {use_slow, en_fast}, 2'b10);
    gapcnt = 0;
    for (int k = 0; k < 20 && !en_slow; k++) begin
      gapcnt++;
      @(negedge clk);
    end
    check(gapcnt == GAP, "R2", "dead gap into slow", gapcnt, GAP);
    as_n = 1'b0; @(negedge clk); ack_n = 1'b0; @(negedge clk);
    as_n = 1'b1; ack_n = 1'b1; board_sel = 1'b0;

    // R9: no ticks, stays slow
    repeat (20) @(negedge clk);
    check(use_slow == 1 && en_slow == 1, "R9", "left slow without ticks",
          {use_slow, en_slow}, 2'b11);
    tick_mode = 1;
    for (int k = 0; k < 40 && use_slow; k++) @(negedge clk);
    check(use_slow == 0, "R5", "return after hold-off", use_slow, 0);
    gapcnt = 0;
    for (int k = 0; k < 20 && !en_fast; k++) begin
      check(!en_slow, "R7", "slow enable during gap", en_slow, 0);
      gapcnt++;
      @(negedge clk);
    end
    check(gapcnt == GAP, "R7", "dead gap into fast", gapcnt, GAP);
    repeat (5) @(negedge clk);

    // single access
    r0 = rises; f0 = falls;
    board_access();
    repeat (30) @(negedge clk);
    check(rises - r0 == 1 && falls - f0 == 1, "R5", "single access switches",
          rises - r0, 1);

    // two word accesses back to back: one switch
    r0 = rises; f0 = falls;
    board_access();
    @(negedge clk);
    board_access();
    repeat (30) @(negedge clk);
    check(rises - r0 == 1, "R6", "paired word accesses, slow entries", rises - r0, 1);
    check(falls - f0 == 1, "R6", "paired word accesses, fast returns", falls - f0, 1);

    // accesses apart by more than the hold-off: two switches
    r0 = rises;
    board_access();
    repeat (25) @(negedge clk);
    board_access();
    repeat (30) @(negedge clk);
    check(rises - r0 == 2, "R8", "separated accesses", rises - r0, 2);
    check(en_fast == 1, "R8", "fast at end", en_fast, 1);

    // constrained random traffic checked against the model
    tick_mode = 2;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      board_sel = ($urandom % 4 == 0);
      as_n      = ($urandom % 3 != 0);
      ack_n     = ($urandom % 4 != 0);
    end
    board_sel = 1'b0; as_n = 1'b1; ack_n = 1'b1;
    repeat (40) @(negedge clk);
    check(en_fast == 1, "R5", "idle settles to fast", en_fast, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule